// File: doc/BRIEF.md
# Software-Refilled Set-Associative Data TLB

This block translates 32-bit data addresses for a processor that refills its translation cache in software. Pages are 8 KB. The cache has four ways of sixteen entries each. The low four bits of the virtual page number pick one set, and the four ways of that set are compared in parallel. The result comes back one cycle after the request. It is either a physical address built from the stored frame number, or a fault carrying a four-bit exception vector code.

A fault is given one of four ordered classes: miss, invalid entry, wrong process, or write-protect. On a fault the block records the page, the access direction and the current process ID in a cause register. On a miss or an invalid entry it also loads a select register with the set index.

Software refills an entry in three register writes. It writes the select register to choose the way and the set. It writes the high staging register, and that value is also copied into the cause register. It then writes the low staging register. That last write commits the entry, using the low value as the entry's low word and the current cause value as its high word. The high and low writes act only while the bank-select input reads 1 or 2. When the global enable is low, addresses pass through unchanged.

Top module: `swRefillTlb`

## Requirements
- R1: A request with `mmuEnable` high takes the page number from address bits 31:13 and the set index from page bits 3:0. If a valid-for-lookup way holds that page number and no check fails, `rspValid` rises one cycle after the request with `rspFault` low, `rspVector` 0, and `rspPaddr` = {frame from entry low bits 31:13, request address bits 12:0}.
- R2: With `mmuEnable` low, the response arrives one cycle later with `rspPaddr` equal to the request address and no fault. The cause and select registers are left unchanged.
- R3: When no way matches (a miss), the response faults with vector 0x8. The select register (address 2) then reads the set index in bits 3:0, with bits 5:4 (the way field) cleared.
- R4: When the valid check is enabled (config bit 16) and the matched entry's low word bit 3 is clear, the response faults with vector 0x9. The select register is loaded as on a miss. This check wins over the process and write checks.
- R5: When the matched entry is not global (low bit 4 clear) and its process ID (high bits 7:0) is neither 0xFF nor `curPid`, the response faults with vector 0xA. This check wins over the write check. A global entry, or an entry with process ID 0xFF, passes this check.
- R6: When a write request meets an enabled write check (config bit 19) and the entry's writable bit (low bit 1) is clear, the response faults with vector 0xB. With the write check disabled, such writes translate normally.
- R7: On every fault the cause register (address 1, read-only to software writes) becomes {page number in bits 31:13, zero in bits 12:10, direction code in bits 9:8 (01 read, 10 write), `curPid` in bits 7:0}.
- R8: A software write to the high staging register (address 4) is copied into the cause register while `bankSel` is 1 or 2. At any other bank value the write has no effect on the cause register.
- R9: A software write to the low staging register (address 3) while `bankSel` is 1 or 2 commits an entry. The way comes from select bits 5:4 and the set from select bits 3:0. The low word is the written value, and the page number and process ID come from the current cause register. At any other bank value the write commits nothing.
- R10: After reset, no entry matches any address, and the config (address 0), cause and select registers all read zero.
- R11: When several ways hold the same page number, the lowest-numbered way supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mmuEnable | input | 1 | Global translation enable; low means pass-through |
| bankSel | input | 4 | Bank-select value; staging writes act only at 1 or 2 |
| curPid | input | 8 | Current process ID |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Request is a store |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspPaddr | output | 32 | Physical address (zero on a fault) |
| rspFault | output | 1 | Translation failed |
| rspVector | output | 4 | Fault vector code (0 when no fault) |
| regWrEn | input | 1 | Special-register write strobe |
| regWrAddr | input | 3 | Write address: 0 config, 1 cause, 2 select, 3 low, 4 high |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 3 | Read address, same map |
| regRdData | output | 32 | Combinational read data |

## Verification
The hardest cases to reach are those where two fault classes compete on one entry. An entry with the invalid flag and a foreign process ID must still report 0x9 until the valid check is turned off, and only then does it report 0xA. Another hard case is a commit whose high word never passed through the high register. In that case the page number and process ID come from a cause value left by an earlier miss. The stimulus reaches this by letting a miss fill both the cause and select registers. A low-register write attempted under a bank value other than 1 or 2 must then leave the miss unchanged. The same write repeated under bank 2 must turn that address into a hit.

// File: rtl/tlbPkg.sv
package tlbPkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 13;
  localparam int VPN_W     = ADDR_W - PAGE_BITS;
  localparam int NUM_WAYS  = 4;
  localparam int NUM_SETS  = 16;
  localparam int WAY_W     = $clog2(NUM_WAYS);
  localparam int IDX_W     = $clog2(NUM_SETS);
  localparam int PID_W     = 8;
  localparam int FLAG_W    = 5;
  localparam int SEL_W     = WAY_W + IDX_W;
  localparam int VEC_W     = 4;
  localparam int RADDR_W   = 3;

  // flag positions inside the low word
  localparam int FL_GLOBAL = 4;
  localparam int FL_VALID  = 3;
  localparam int FL_WRITE  = 1;
  // config check-enable positions
  localparam int CFG_WCHK  = 19;
  localparam int CFG_VCHK  = 16;

  localparam logic [VEC_W-1:0] VEC_NONE  = 4'h0;
  localparam logic [VEC_W-1:0] VEC_MISS  = 4'h8;
  localparam logic [VEC_W-1:0] VEC_INVAL = 4'h9;
  localparam logic [VEC_W-1:0] VEC_PID   = 4'hA;
  localparam logic [VEC_W-1:0] VEC_WPROT = 4'hB;

  localparam logic [RADDR_W-1:0] RA_CFG   = 3'd0;
  localparam logic [RADDR_W-1:0] RA_CAUSE = 3'd1;
  localparam logic [RADDR_W-1:0] RA_SEL   = 3'd2;
  localparam logic [RADDR_W-1:0] RA_LO    = 3'd3;
  localparam logic [RADDR_W-1:0] RA_HI    = 3'd4;

  typedef struct packed {
    logic               commitEn;
    logic [WAY_W-1:0]   commitWay;
    logic [IDX_W-1:0]   commitIdx;
    logic [VPN_W-1:0]   commitVpn;
    logic [PID_W-1:0]   commitPid;
    logic [VPN_W-1:0]   commitPfn;
    logic [FLAG_W-1:0]  commitFlags;
    logic               chkValid;
    logic               chkWrite;
  } ctrlStrobe_t;

  typedef struct packed {
    logic               evt;
    logic               loadSel;
    logic [IDX_W-1:0]   idx;
    logic [ADDR_W-1:0]  cause;
  } faultEvt_t;
endpackage

// File: rtl/tlbData.sv
module tlbData
  import tlbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              mmuEnable,
  input  logic [PID_W-1:0]  curPid,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output faultEvt_t         faultEvt,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspFault,
  output logic [VEC_W-1:0]  rspVector
);
  logic [VPN_W-1:0]  vpnMem   [NUM_WAYS][NUM_SETS];
  logic [PID_W-1:0]  pidMem   [NUM_WAYS][NUM_SETS];
  logic [VPN_W-1:0]  pfnMem   [NUM_WAYS][NUM_SETS];
  logic [FLAG_W-1:0] flagMem  [NUM_WAYS][NUM_SETS];
  logic [NUM_WAYS-1:0][NUM_SETS-1:0] presentBits;

  always_ff @(posedge clk) begin
    if (strobe.commitEn) begin
      vpnMem[strobe.commitWay][strobe.commitIdx]  <= strobe.commitVpn;
      pidMem[strobe.commitWay][strobe.commitIdx]  <= strobe.commitPid;
      pfnMem[strobe.commitWay][strobe.commitIdx]  <= strobe.commitPfn;
      flagMem[strobe.commitWay][strobe.commitIdx] <= strobe.commitFlags;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presentBits <= '0;
    else if (strobe.commitEn) presentBits[strobe.commitWay][strobe.commitIdx] <= 1'b1;
  end

  logic [VPN_W-1:0]    reqVpn;
  logic [IDX_W-1:0]    reqIdx;
  logic [NUM_WAYS-1:0] wayHit;
  assign reqVpn = reqVaddr[ADDR_W-1:PAGE_BITS];
  assign reqIdx = reqVpn[IDX_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign wayHit[w] = presentBits[w][reqIdx] && (vpnMem[w][reqIdx] == reqVpn);
  end

  logic [WAY_W-1:0]  hitWay;
  logic [PID_W-1:0]  hitPid;
  logic [VPN_W-1:0]  hitPfn;
  logic [FLAG_W-1:0] hitFlags;
  always_comb begin
    hitWay = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (wayHit[w]) hitWay = WAY_W'(w);
  end
  assign hitPid   = pidMem[hitWay][reqIdx];
  assign hitPfn   = pfnMem[hitWay][reqIdx];
  assign hitFlags = flagMem[hitWay][reqIdx];

  logic [VEC_W-1:0] vecNext;
  always_comb begin
    if (wayHit == '0)
      vecNext = VEC_MISS;
    else if (strobe.chkValid && !hitFlags[FL_VALID])
      vecNext = VEC_INVAL;
    else if (!hitFlags[FL_GLOBAL] && hitPid != {PID_W{1'b1}} && hitPid != curPid)
      vecNext = VEC_PID;
    else if (reqWrite && strobe.chkWrite && !hitFlags[FL_WRITE])
      vecNext = VEC_WPROT;
    else
      vecNext = VEC_NONE;
  end

  assign faultEvt.evt     = reqValid && mmuEnable && (vecNext != VEC_NONE);
  assign faultEvt.loadSel = (vecNext == VEC_MISS) || (vecNext == VEC_INVAL);
  assign faultEvt.idx     = reqIdx;
  assign faultEvt.cause   = {reqVpn, 3'b000, reqWrite, !reqWrite, curPid};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspPaddr  <= '0;
      rspFault  <= 1'b0;
      rspVector <= VEC_NONE;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        if (!mmuEnable) begin
          rspPaddr  <= reqVaddr;
          rspFault  <= 1'b0;
          rspVector <= VEC_NONE;
        end else if (vecNext != VEC_NONE) begin
          rspPaddr  <= '0;
          rspFault  <= 1'b1;
          rspVector <= vecNext;
        end else begin
          rspPaddr  <= {hitPfn, reqVaddr[PAGE_BITS-1:0]};
          rspFault  <= 1'b0;
          rspVector <= VEC_NONE;
        end
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1
  AST_BYPASS_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mmuEnable) |=> (!rspFault && rspPaddr == $past(reqVaddr))); // R2
  AST_FAULT_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault == (rspVector != VEC_NONE))); // R3
endmodule

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          bankSel,
  input  logic                regWrEn,
  input  logic [RADDR_W-1:0]  regWrAddr,
  input  logic [ADDR_W-1:0]   regWrData,
  input  logic [RADDR_W-1:0]  regRdAddr,
  output logic [ADDR_W-1:0]   regRdData,
  input  faultEvt_t           faultEvt,
  output ctrlStrobe_t         strobe
);
  logic [ADDR_W-1:0] cfgReg, causeReg, loReg, hiReg;
  logic [SEL_W-1:0]  selReg;
  logic              bankOk;
  logic              wrCfg, wrSel, wrLo, wrHi;

  assign bankOk = (bankSel == 4'd1) || (bankSel == 4'd2);
  assign wrCfg  = regWrEn && (regWrAddr == RA_CFG);
  assign wrSel  = regWrEn && (regWrAddr == RA_SEL);
  assign wrLo   = regWrEn && (regWrAddr == RA_LO) && bankOk;
  assign wrHi   = regWrEn && (regWrAddr == RA_HI) && bankOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      causeReg <= '0;
      selReg   <= '0;
      loReg    <= '0;
      hiReg    <= '0;
    end else begin
      if (wrCfg) cfgReg <= regWrData;
      if (wrLo)  loReg  <= regWrData;
      if (wrHi)  hiReg  <= regWrData;
      if (faultEvt.evt)  causeReg <= faultEvt.cause;
      else if (wrHi)     causeReg <= regWrData;
      if (faultEvt.evt && faultEvt.loadSel) selReg <= {{WAY_W{1'b0}}, faultEvt.idx};
      else if (wrSel)                       selReg <= regWrData[SEL_W-1:0];
    end
  end

  always_comb begin
    strobe.commitEn    = wrLo;
    strobe.commitWay   = selReg[SEL_W-1:IDX_W];
    strobe.commitIdx   = selReg[IDX_W-1:0];
    strobe.commitVpn   = causeReg[ADDR_W-1:PAGE_BITS];
    strobe.commitPid   = causeReg[PID_W-1:0];
    strobe.commitPfn   = regWrData[ADDR_W-1:PAGE_BITS];
    strobe.commitFlags = regWrData[FLAG_W-1:0];
    strobe.chkValid    = cfgReg[CFG_VCHK];
    strobe.chkWrite    = cfgReg[CFG_WCHK];
  end

  always_comb begin
    case (regRdAddr)
      RA_CFG:   regRdData = cfgReg;
      RA_CAUSE: regRdData = causeReg;
      RA_SEL:   regRdData = {{(ADDR_W-SEL_W){1'b0}}, selReg};
      RA_LO:    regRdData = loReg;
      RA_HI:    regRdData = hiReg;
      default:  regRdData = '0;
    endcase
  end

  AST_HI_MIRRORS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrAddr == RA_HI && bankOk && !faultEvt.evt) |=> (causeReg == $past(regWrData))); // R8
  AST_CAUSE_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrAddr == RA_CAUSE && !faultEvt.evt) |=> $stable(causeReg)); // R7
  AST_MISS_CLEARS_WAY: assert property (@(posedge clk) disable iff (!rstN)
    (faultEvt.evt && faultEvt.loadSel) |=> (selReg[SEL_W-1:IDX_W] == '0)); // R3
  AST_FAULT_CAUSE_PID: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt.evt |=> (causeReg[PID_W-1:0] == $past(faultEvt.cause[PID_W-1:0]))); // R7
endmodule

// File: rtl/swRefillTlb.sv
module swRefillTlb
  import tlbPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                mmuEnable,
  input  logic [3:0]          bankSel,
  input  logic [PID_W-1:0]    curPid,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqVaddr,
  input  logic                reqWrite,
  output logic                rspValid,
  output logic [ADDR_W-1:0]   rspPaddr,
  output logic                rspFault,
  output logic [VEC_W-1:0]    rspVector,
  input  logic                regWrEn,
  input  logic [RADDR_W-1:0]  regWrAddr,
  input  logic [ADDR_W-1:0]   regWrData,
  input  logic [RADDR_W-1:0]  regRdAddr,
  output logic [ADDR_W-1:0]   regRdData
);
  ctrlStrobe_t strobe;
  faultEvt_t   faultEvt;

  tlbCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .bankSel(bankSel),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .faultEvt(faultEvt), .strobe(strobe)
  );

  tlbData data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mmuEnable(mmuEnable), .curPid(curPid),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .faultEvt(faultEvt), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .rspVector(rspVector)
  );
endmodule

// File: tb/swRefillTlb_tb_top.sv
`timescale 1ns/1ps
module swRefillTlb_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mmuEnable = 1'b1;
  logic [3:0]  bankSel = 4'd0;
  logic [7:0]  curPid = 8'd0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspFault;
  logic [3:0]  rspVector;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [31:0] regRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] qPaddr[$];
  logic        qFault[$];
  logic [3:0]  qVec[$];
  string       qTag[$];

  always #2.5 clk = ~clk;

  swRefillTlb dut_i (
    .clk(clk), .rstN(rstN), .mmuEnable(mmuEnable), .bankSel(bankSel), .curPid(curPid),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault), .rspVector(rspVector),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCause(input logic [18:0] vpn, input bit wr, input logic [7:0] pid);
    return {vpn, 3'b000, wr, !wr, pid};
  endfunction

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkReg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    regRdAddr = a;
    #1;
    check(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic lookup(input logic [31:0] va, input bit wr, input bit expFault,
                        input logic [3:0] expVec, input logic [31:0] expPa, input string tag);
    qPaddr.push_back(expPa); qFault.push_back(expFault); qVec.push_back(expVec); qTag.push_back(tag);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compares each response against the oldest expected item
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (qTag.size() == 0) begin
        check(1'b0, "unexpected response", {28'h0, rspVector}, 32'h0);
      end else begin
        logic [31:0] ePa;
        logic        eF;
        logic [3:0]  eV;
        string       t;
        ePa = qPaddr.pop_front(); eF = qFault.pop_front();
        eV = qVec.pop_front(); t = qTag.pop_front();
        check(rspFault === eF, {t, " fault"}, {31'h0, rspFault}, {31'h0, eF});
        check(rspVector === eV, {t, " vector"}, {28'h0, rspVector}, {28'h0, eV});
        if (!eF) check(rspPaddr === ePa, {t, " paddr"}, rspPaddr, ePa);
      end
    end
  end

  localparam logic [18:0] VPN_A = 19'h000A5;
  localparam logic [18:0] VPN_B = 19'h000B6;
  localparam logic [18:0] VPN_C = 19'h000C7;
  localparam logic [18:0] VPN_D = 19'h000D8;
  localparam logic [18:0] VPN_M = 19'h001F9;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    checkReg(3'd0, 32'h0, "R10 config after reset");
    checkReg(3'd1, 32'h0, "R10 cause after reset");
    checkReg(3'd2, 32'h0, "R10 select after reset");
    lookup(32'h0000_0000, 1'b0, 1'b1, 4'h8, 32'h0, "R10 empty entry misses");
    checkReg(3'd2, 32'h0, "R10 select after first miss");

    bankSel = 4'd1;
    regWrite(3'd0, 32'h0009_0000);
    checkReg(3'd0, 32'h0009_0000, "R10 config readback");

    // entry A: way1 set5, pid 7, valid+writable
    regWrite(3'd2, 32'h15);
    regWrite(3'd4, {VPN_A, 13'h0} | 32'h07);
    checkReg(3'd1, {VPN_A, 13'h0} | 32'h07, "R8 high copied into cause");
    regWrite(3'd1, 32'h1234_5678);
    checkReg(3'd1, {VPN_A, 13'h0} | 32'h07, "R7 cause ignores direct write");
    regWrite(3'd3, {19'h003C0, 13'h0} | 32'h0A);
    curPid = 8'h07;
    lookup({VPN_A, 13'h0123}, 1'b0, 1'b0, 4'h0, {19'h003C0, 13'h0123}, "R1 read hit");
    lookup({VPN_A, 13'h1FFF}, 1'b1, 1'b0, 4'h0, {19'h003C0, 13'h1FFF}, "R1 write hit");

    curPid = 8'h03;
    lookup({VPN_A, 13'h0004}, 1'b0, 1'b1, 4'hA, 32'h0, "R5 foreign pid");
    checkReg(3'd1, mkCause(VPN_A, 1'b0, 8'h03), "R7 cause after pid fault");
    checkReg(3'd2, 32'h15, "R5 select untouched by pid fault");

    // entry B: way2 set6, pid 0x44, not valid, not writable
    regWrite(3'd2, 32'h26);
    regWrite(3'd4, {VPN_B, 13'h0} | 32'h44);
    regWrite(3'd3, {19'h00222, 13'h0});
    lookup({VPN_B, 13'h0010}, 1'b0, 1'b1, 4'h9, 32'h0, "R4 invalid beats pid");
    checkReg(3'd2, 32'h06, "R4 select loaded on invalid");
    regWrite(3'd0, 32'h0008_0000);
    lookup({VPN_B, 13'h0010}, 1'b0, 1'b1, 4'hA, 32'h0, "R5 pid after valid check off");
    curPid = 8'h44;
    lookup({VPN_B, 13'h0010}, 1'b0, 1'b0, 4'h0, {19'h00222, 13'h0010}, "R1 invalid entry usable");
    lookup({VPN_B, 13'h0020}, 1'b1, 1'b1, 4'hB, 32'h0, "R6 write protect");
    checkReg(3'd1, mkCause(VPN_B, 1'b1, 8'h44), "R7 cause write code");
    regWrite(3'd0, 32'h0);
    lookup({VPN_B, 13'h0020}, 1'b1, 1'b0, 4'h0, {19'h00222, 13'h0020}, "R6 check disabled");

    // entry C: pid wildcard 0xFF; entry D: global
    curPid = 8'h03;
    regWrite(3'd2, 32'h37);
    regWrite(3'd4, {VPN_C, 13'h0} | 32'hFF);
    regWrite(3'd3, {19'h00333, 13'h0} | 32'h08);
    lookup({VPN_C, 13'h0ABC}, 1'b0, 1'b0, 4'h0, {19'h00333, 13'h0ABC}, "R5 wildcard pid");
    regWrite(3'd2, 32'h08);
    regWrite(3'd4, {VPN_D, 13'h0} | 32'h55);
    regWrite(3'd3, {19'h00444, 13'h0} | 32'h18);
    lookup({VPN_D, 13'h0001}, 1'b0, 1'b0, 4'h0, {19'h00444, 13'h0001}, "R5 global entry");

    // miss, then refill from cause
    lookup({VPN_M, 13'h0077}, 1'b0, 1'b1, 4'h8, 32'h0, "R3 miss");
    checkReg(3'd2, 32'h09, "R3 select after miss");
    checkReg(3'd1, mkCause(VPN_M, 1'b0, 8'h03), "R7 cause after miss");
    bankSel = 4'd0;
    regWrite(3'd4, 32'hDEAD_BEEF);
    checkReg(3'd1, mkCause(VPN_M, 1'b0, 8'h03), "R8 high ignored off bank");
    regWrite(3'd3, {19'h00555, 13'h0} | 32'h08);
    lookup({VPN_M, 13'h0077}, 1'b0, 1'b1, 4'h8, 32'h0, "R9 commit ignored off bank");
    bankSel = 4'd2;
    regWrite(3'd3, {19'h00555, 13'h0} | 32'h08);
    lookup({VPN_M, 13'h0077}, 1'b0, 1'b0, 4'h0, {19'h00555, 13'h0077}, "R9 commit uses cause");

    // pass-through
    mmuEnable = 1'b0;
    lookup(32'hFFFF_E123, 1'b1, 1'b0, 4'h0, 32'hFFFF_E123, "R2 pass-through");
    checkReg(3'd1, mkCause(VPN_M, 1'b0, 8'h03), "R2 cause untouched");
    checkReg(3'd2, 32'h09, "R2 select untouched");
    mmuEnable = 1'b1;

    // duplicate page in way0 set5 beside way1
    curPid = 8'h07;
    regWrite(3'd2, 32'h05);
    regWrite(3'd4, {VPN_A, 13'h0} | 32'h07);
    regWrite(3'd3, {19'h00111, 13'h0} | 32'h0A);
    lookup({VPN_A, 13'h0042}, 1'b0, 1'b0, 4'h0, {19'h00111, 13'h0042}, "R11 lowest way wins");

    repeat (3) @(negedge clk);
    check(qTag.size() == 0, "responses outstanding", qTag.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule